// File: doc/BRIEF.md
# Storage-Card Host Register Front End

This block is the host-side register file of a serial storage-card controller. It is a 32-bit Wishbone slave with seven word-aligned registers. Host software uses it to set a control word and a clock divisor, to read status and card-presence words supplied by other logic, and to move payload through three data ports that are 8, 16 and 32 bits wide. A write to any data port packs the host bytes into the top of a 32-bit transmit word. The block then tells the downstream shift engine how many bits are valid. A read from a data port returns the receive word right-justified, with zeros above it.

One control bit sets the byte order for every data port. When the bit is 1, bytes pass straight through. When it is 0, the bytes inside the access width are reversed, in both directions. After reset the bit is 0, so the reversed order is the default.

Bus handling is a two-state machine. In state `BUS_IDLE` the block waits for a request. When cycle and strobe are both high, the transition `IDLE_TO_ACK` commits the write, or latches the read data, at that clock edge. State `BUS_ACK` drives the acknowledge for exactly one cycle. The transition `ACK_TO_IDLE` then happens unconditionally, so a request that is held high is answered every other cycle.

Top module: `card_host_regs`

Register word offsets (ADR_I, byte addresses):

| Offset | Register | Access |
|---|---|---|
| 0x00 | 8-bit data port | read/write |
| 0x04 | 16-bit data port | read/write |
| 0x08 | 32-bit data port | read/write |
| 0x0C | control | read/write |
| 0x10 | status | read-only |
| 0x14 | clock divisor | read/write |
| 0x18 | card detect | read-only |

## Requirements
- R1: After a synchronous reset the outputs read as follows: control word is 0, clock divisor is 0, transmit word is 0, and acknowledge and load strobe are both low.
- R2: A request (cyc_i and stb_i high at an edge while idle) is acknowledged in the next cycle. The acknowledge lasts exactly one cycle and is never high in two consecutive cycles.
- R3: A write to 0x0C stores host bits 5..1 only. The control register reads back and drives ctrl_o with all other bits 0. Bit 5 is the order bit: 1 means straight order, 0 means bytes reversed.
- R4: A write to 0x00 sets the transmit word to {dat_i[7:0], 24'b0} with size code 2'b00, in either byte order.
- R5: A write to 0x04 sets the transmit word to {dat_i[15:0], 16'b0} when the order bit is 1, or to {dat_i[7:0], dat_i[15:8], 16'b0} when it is 0. The size code is 2'b01.
- R6: A write to 0x08 sets the transmit word to dat_i when the order bit is 1, or to dat_i with its four bytes reversed when it is 0. The size code is 2'b10.
- R7: Only data-port writes raise tx_load_o. It rises for one cycle, together with the acknowledge. The transmit word changes only in a cycle when the strobe is high.
- R8: A write to 0x14 stores dat_i[15:0] in the clock divisor. The divisor reads back zero-extended to 32 bits.
- R9: A read of 0x00 returns {24'b0, rx_word_i[7:0]}.
- R10: A read of 0x04 returns {16'b0, rx[15:0]} when the order bit is 1, or {16'b0, rx[7:0], rx[15:8]} when it is 0.
- R11: A read of 0x08 returns rx_word_i when the order bit is 1, or rx_word_i with its bytes reversed when it is 0.
- R12: Reads of 0x10 and 0x18 return status_i and card_sense_i. Writes to 0x10, 0x18 and 0x1C change no register and raise no load strobe. A read of 0x1C returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| cyc_i | input | 1 | Bus cycle valid |
| stb_i | input | 1 | Bus strobe |
| we_i | input | 1 | Write enable |
| adr_i | input | 5 | Byte address |
| dat_i | input | 32 | Write data |
| dat_o | output | 32 | Read data, valid with ack_o |
| ack_o | output | 1 | One-cycle acknowledge |
| rx_word_i | input | 32 | Receive word from the shift engine |
| status_i | input | 32 | Status word |
| card_sense_i | input | 32 | Card-detect word |
| ctrl_o | output | 32 | Control register |
| clkdiv_o | output | 16 | Clock divisor register |
| tx_word_o | output | 32 | Transmit word |
| tx_load_o | output | 1 | Transmit load strobe |
| tx_size_o | output | 2 | Access size: 00 = 8, 01 = 16, 10 = 32 bits |

## Verification
Every result is due one clock edge after the request is sampled. At that edge the acknowledge, the read data, the transmit word with its size code and load strobe, and the register outputs all change together. The driver raises a request on a falling edge and drops it on the next falling edge. The monitor compares the outputs at that same falling edge whenever the acknowledge is high, against the item the driver queued. A held-request test checks the low acknowledge in the middle cycle. A load strobe seen without an acknowledge is reported at whichever falling edge it appears.

// File: rtl/card_regs_pkg.sv
package card_regs_pkg;

    // register word indices (byte offset / 4)
    localparam int IDX_DATA8  = 0;
    localparam int IDX_DATA16 = 1;
    localparam int IDX_DATA32 = 2;
    localparam int IDX_CTRL   = 3;
    localparam int IDX_STATUS = 4;
    localparam int IDX_CDIV   = 5;
    localparam int IDX_CARD   = 6;

    // writable control field and the order-select bit within it
    localparam int CTRL_LO   = 1;
    localparam int CTRL_HI   = 5;
    localparam int ORDER_BIT = 5;

    typedef enum logic [1:0] {
        SIZE_8  = 2'b00,
        SIZE_16 = 2'b01,
        SIZE_32 = 2'b10
    } xfer_size_t;

    typedef enum logic {
        BUS_IDLE = 1'b0,
        BUS_ACK  = 1'b1
    } bus_state_t;

endpackage

// File: rtl/creg_bus_fsm.sv
module creg_bus_fsm
    import card_regs_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic cyc_i,
    input  logic stb_i,
    output logic fire_o,
    output logic ack_o
);

    bus_state_t state_q;
    bus_state_t state_d;

    // state register
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= BUS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: IDLE_TO_ACK on request, ACK_TO_IDLE always
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: if (cyc_i && stb_i) state_d = BUS_ACK;
            BUS_ACK:  state_d = BUS_IDLE;
            default:  state_d = BUS_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        fire_o = 1'b0;
        ack_o  = 1'b0;
        unique case (state_q)
            BUS_IDLE: fire_o = cyc_i && stb_i;
            BUS_ACK:  ack_o  = 1'b1;
            default:  ack_o  = 1'b0;
        endcase
    end

endmodule

// File: rtl/creg_tx_packer.sv
module creg_tx_packer
    import card_regs_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              swap_i,
    input  xfer_size_t        size_i,
    input  logic [DATA_W-1:0] din_i,
    output logic [DATA_W-1:0] word_o
);

    localparam int LANES = DATA_W / 8;

    logic [DATA_W-1:0] rev_full;
    logic [15:0]       half_sel;

    // full-width byte reversal
    for (genvar g = 0; g < LANES; g++) begin : g_rev
        assign rev_full[8*g +: 8] = din_i[DATA_W-8-8*g +: 8];
    end

    assign half_sel = swap_i ? {din_i[7:0], din_i[15:8]} : din_i[15:0];

    // left-justified packing, uncovered bits cleared
    always_comb begin
        word_o = '0;
        unique case (size_i)
            SIZE_8:  word_o[DATA_W-1 -: 8]  = din_i[7:0];
            SIZE_16: word_o[DATA_W-1 -: 16] = half_sel;
            SIZE_32: word_o = swap_i ? rev_full : din_i;
            default: word_o = '0;
        endcase
    end

endmodule

// File: rtl/creg_rx_view.sv
module creg_rx_view
    import card_regs_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 3,
    parameter int DIV_W  = 16
) (
    input  logic [IDX_W-1:0]   idx_i,
    input  logic               swap_i,
    input  logic [DATA_W-1:0]  rx_i,
    input  logic [DATA_W-1:0]  status_i,
    input  logic [DATA_W-1:0]  card_i,
    input  logic [DATA_W-1:0]  ctrl_i,
    input  logic [DIV_W-1:0]   cdiv_i,
    output logic [DATA_W-1:0]  word_o
);

    localparam int LANES = DATA_W / 8;

    logic [DATA_W-1:0] rev_full;
    logic [15:0]       half_sel;

    for (genvar g = 0; g < LANES; g++) begin : g_rev
        assign rev_full[8*g +: 8] = rx_i[DATA_W-8-8*g +: 8];
    end

    assign half_sel = swap_i ? {rx_i[7:0], rx_i[15:8]} : rx_i[15:0];

    // right-justified, zero-extended read view
    always_comb begin
        word_o = '0;
        if (idx_i == IDX_W'(IDX_DATA8)) begin
            word_o[7:0] = rx_i[7:0];
        end else if (idx_i == IDX_W'(IDX_DATA16)) begin
            word_o[15:0] = half_sel;
        end else if (idx_i == IDX_W'(IDX_DATA32)) begin
            word_o = swap_i ? rev_full : rx_i;
        end else if (idx_i == IDX_W'(IDX_CTRL)) begin
            word_o = ctrl_i;
        end else if (idx_i == IDX_W'(IDX_STATUS)) begin
            word_o = status_i;
        end else if (idx_i == IDX_W'(IDX_CDIV)) begin
            word_o[DIV_W-1:0] = cdiv_i;
        end else if (idx_i == IDX_W'(IDX_CARD)) begin
            word_o = card_i;
        end
    end

endmodule

// File: rtl/card_host_regs.sv
module card_host_regs
    import card_regs_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADR_W  = 5,
    parameter int DIV_W  = 16
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              cyc_i,
    input  logic              stb_i,
    input  logic              we_i,
    input  logic [ADR_W-1:0]  adr_i,
    input  logic [DATA_W-1:0] dat_i,
    output logic [DATA_W-1:0] dat_o,
    output logic              ack_o,
    input  logic [DATA_W-1:0] rx_word_i,
    input  logic [DATA_W-1:0] status_i,
    input  logic [DATA_W-1:0] card_sense_i,
    output logic [DATA_W-1:0] ctrl_o,
    output logic [DIV_W-1:0]  clkdiv_o,
    output logic [DATA_W-1:0] tx_word_o,
    output logic              tx_load_o,
    output logic [1:0]        tx_size_o
);

    localparam int IDX_W  = ADR_W - 2;
    localparam int CTRL_W = CTRL_HI - CTRL_LO + 1;

    logic [IDX_W-1:0]  idx;
    logic              unused_adr_lsb;
    logic              fire;
    logic              swap;
    logic              is_data;
    xfer_size_t        size_sel;
    logic [DATA_W-1:0] packed_word;
    logic [DATA_W-1:0] read_word;

    logic [CTRL_W-1:0] ctrl_q;
    logic [DIV_W-1:0]  cdiv_q;
    logic [DATA_W-1:0] tx_q;
    logic              load_q;
    xfer_size_t        size_q;
    logic [DATA_W-1:0] rdat_q;

    assign idx            = adr_i[ADR_W-1:2];
    assign unused_adr_lsb = ^adr_i[1:0];

    always_comb begin
        ctrl_o = '0;
        ctrl_o[CTRL_HI:CTRL_LO] = ctrl_q;
    end

    // order bit 0 selects reversed bytes
    assign swap = ~ctrl_o[ORDER_BIT];

    always_comb begin
        is_data  = 1'b1;
        size_sel = SIZE_8;
        if (idx == IDX_W'(IDX_DATA16))      size_sel = SIZE_16;
        else if (idx == IDX_W'(IDX_DATA32)) size_sel = SIZE_32;
        else if (idx != IDX_W'(IDX_DATA8))  is_data  = 1'b0;
    end

    creg_bus_fsm u_fsm (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .cyc_i  (cyc_i),
        .stb_i  (stb_i),
        .fire_o (fire),
        .ack_o  (ack_o)
    );

    creg_tx_packer #(.DATA_W(DATA_W)) u_pack (
        .swap_i (swap),
        .size_i (size_sel),
        .din_i  (dat_i),
        .word_o (packed_word)
    );

    creg_rx_view #(.DATA_W(DATA_W), .IDX_W(IDX_W), .DIV_W(DIV_W)) u_view (
        .idx_i    (idx),
        .swap_i   (swap),
        .rx_i     (rx_word_i),
        .status_i (status_i),
        .card_i   (card_sense_i),
        .ctrl_i   (ctrl_o),
        .cdiv_i   (cdiv_q),
        .word_o   (read_word)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ctrl_q <= '0;
            cdiv_q <= '0;
            tx_q   <= '0;
            load_q <= 1'b0;
            size_q <= SIZE_8;
            rdat_q <= '0;
        end else begin
            load_q <= 1'b0;
            if (fire) begin
                rdat_q <= we_i ? '0 : read_word;
                if (we_i) begin
                    if (is_data) begin
                        tx_q   <= packed_word;
                        size_q <= size_sel;
                        load_q <= 1'b1;
                    end else if (idx == IDX_W'(IDX_CTRL)) begin
                        ctrl_q <= dat_i[CTRL_HI:CTRL_LO];
                    end else if (idx == IDX_W'(IDX_CDIV)) begin
                        cdiv_q <= dat_i[DIV_W-1:0];
                    end
                end
            end
        end
    end

    assign dat_o     = rdat_q;
    assign clkdiv_o  = cdiv_q;
    assign tx_word_o = tx_q;
    assign tx_load_o = load_q;
    assign tx_size_o = size_q;

endmodule

// File: rtl/creg_checker.sv
module creg_checker #(
    parameter int DATA_W = 32,
    parameter int DIV_W  = 16
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              cyc_i,
    input logic              stb_i,
    input logic              ack_o,
    input logic              tx_load_o,
    input logic [1:0]        tx_size_o,
    input logic [DATA_W-1:0] tx_word_o,
    input logic [DIV_W-1:0]  clkdiv_o
);

    // R2
    ack_single_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        ack_o |=> !ack_o);

    // R2
    ack_cause_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(ack_o) |-> $past(cyc_i && stb_i));

    // R7
    load_with_ack_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        tx_load_o |-> ack_o);

    // R7
    tx_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !tx_load_o |-> $stable(tx_word_o));

    // R4
    size8_pad_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (tx_load_o && tx_size_o == 2'b00) |-> (tx_word_o[DATA_W-9:0] == '0));

    // R5
    size16_pad_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (tx_load_o && tx_size_o == 2'b01) |-> (tx_word_o[DATA_W-17:0] == '0));

    // R8
    div_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !ack_o |-> $stable(clkdiv_o));

endmodule

bind card_host_regs creg_checker #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_chk (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .cyc_i     (cyc_i),
    .stb_i     (stb_i),
    .ack_o     (ack_o),
    .tx_load_o (tx_load_o),
    .tx_size_o (tx_size_o),
    .tx_word_o (tx_word_o),
    .clkdiv_o  (clkdiv_o)
);

// File: tb/card_host_regs_bench.sv
module card_host_regs_bench;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic        chk_dat;
        logic [31:0] dat;
        logic        load;
        logic [31:0] tx;
        logic [1:0]  size;
        string       tag;
    } exp_item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cyc = 1'b0, stb = 1'b0, we = 1'b0;
    logic [4:0]  adr = '0;
    logic [31:0] wdat = '0;
    logic [31:0] rdat;
    logic        ack;
    logic [31:0] rx = '0, status = '0, card = '0;
    logic [31:0] ctrl;
    logic [15:0] cdiv;
    logic [31:0] tx;
    logic        load;
    logic [1:0]  size;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    exp_item_t   sb[$];
    logic [31:0] m_ctrl = '0;
    logic [31:0] m_cdiv = '0;
    logic [31:0] m_tx   = '0;
    logic [1:0]  m_size = 2'b00;

    always #(CLK_PERIOD/2) clk = ~clk;

    card_host_regs u_card_host_regs (
        .clk_i(clk), .rst_i(rst), .cyc_i(cyc), .stb_i(stb), .we_i(we),
        .adr_i(adr), .dat_i(wdat), .dat_o(rdat), .ack_o(ack),
        .rx_word_i(rx), .status_i(status), .card_sense_i(card),
        .ctrl_o(ctrl), .clkdiv_o(cdiv), .tx_word_o(tx),
        .tx_load_o(load), .tx_size_o(size)
    );

    function automatic logic [31:0] rev4(input logic [31:0] v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pop and compare on every acknowledge
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (load && !ack) check("R7 load without ack", {63'd0, load}, 64'd0);
            if (ack) begin
                if (sb.size() == 0) begin
                    check("R2 unexpected ack", 64'd1, 64'd0);
                end else begin
                    exp_item_t e;
                    e = sb.pop_front();
                    check({e.tag, " load/tx/size"}, {29'd0, load, tx, size},
                                                    {29'd0, e.load, e.tx, e.size});
                    if (e.chk_dat) check({e.tag, " read"}, {32'd0, rdat}, {32'd0, e.dat});
                end
            end
        end
    end

    task automatic push(input logic cd, input logic [31:0] d, input logic ld, input string tag);
        exp_item_t e;
        e.chk_dat = cd; e.dat = d; e.load = ld; e.tx = m_tx; e.size = m_size; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic access(input logic w, input int idx, input logic [31:0] d);
        @(negedge clk);
        cyc = 1'b1; stb = 1'b1; we = w; adr = 5'(idx * 4); wdat = d;
        @(negedge clk);
        cyc = 1'b0; stb = 1'b0; we = 1'b0;
        @(negedge clk);
    endtask

    // driver: write, model expected result
    task automatic wr(input int idx, input logic [31:0] d, input string tag);
        logic ord;
        logic ld;
        ord = m_ctrl[5];
        ld  = 1'b0;
        case (idx)
            0: begin m_tx = {d[7:0], 24'd0}; m_size = 2'b00; ld = 1'b1; end
            1: begin m_tx = ord ? {d[15:0], 16'd0} : {d[7:0], d[15:8], 16'd0};
                     m_size = 2'b01; ld = 1'b1; end
            2: begin m_tx = ord ? d : rev4(d); m_size = 2'b10; ld = 1'b1; end
            3: m_ctrl = d & 32'h0000_003E;
            5: m_cdiv = {16'd0, d[15:0]};
            default: ;
        endcase
        push(1'b0, 32'd0, ld, tag);
        access(1'b1, idx, d);
    endtask

    function automatic logic [31:0] rd_model(input int idx);
        logic ord;
        ord = m_ctrl[5];
        case (idx)
            0: return {24'd0, rx[7:0]};
            1: return ord ? {16'd0, rx[15:0]} : {16'd0, rx[7:0], rx[15:8]};
            2: return ord ? rx : rev4(rx);
            3: return m_ctrl;
            4: return status;
            5: return m_cdiv;
            6: return card;
            default: return 32'd0;
        endcase
    endfunction

    task automatic rd(input int idx, input string tag);
        push(1'b1, rd_model(idx), 1'b0, tag);
        access(1'b0, idx, 32'hFFFF_FFFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 reset outputs", {ctrl, cdiv, 16'd0}, 64'd0);
        check("R1 reset tx/ack/load", {tx, 30'd0, ack, load}, 64'd0);
        rd(3, "R1 ctrl read after reset");

        // reversed order (default)
        wr(0, 32'hAABB_CC5A, "R4 data8 write rev");
        wr(1, 32'h1122_3344, "R5 data16 write rev");
        wr(2, 32'h1122_3344, "R6 data32 write rev");
        rx = 32'h8899_AABB;
        rd(0, "R9 data8 read");
        rd(1, "R10 data16 read rev");
        rd(2, "R11 data32 read rev");

        // control mask and straight order
        wr(3, 32'hFFFF_FFFF, "R3 ctrl write all ones");
        rd(3, "R3 ctrl readback");
        check("R3 ctrl_o port", {32'd0, ctrl}, 64'h3E);
        wr(1, 32'h1122_3344, "R5 data16 write straight");
        wr(2, 32'h1122_3344, "R6 data32 write straight");
        wr(0, 32'h0000_0044, "R4 data8 write straight");
        rd(1, "R10 data16 read straight");
        rd(2, "R11 data32 read straight");
        wr(3, 32'h0000_001F, "R3 ctrl order cleared");
        rd(3, "R3 ctrl readback low bits");
        wr(2, 32'hCAFE_F00D, "R6 data32 write after clear");

        // divisor
        wr(5, 32'hDEAD_1234, "R8 cdiv write");
        rd(5, "R8 cdiv readback");
        check("R8 clkdiv_o port", {48'd0, cdiv}, 64'h1234);

        // read-only and unmapped
        status = 32'h1234_5678;
        card   = 32'h0000_0003;
        rd(4, "R12 status read");
        rd(6, "R12 card read");
        wr(4, 32'hFFFF_FFFF, "R12 status write ignored");
        wr(6, 32'hFFFF_FFFF, "R12 card write ignored");
        wr(7, 32'hFFFF_FFFF, "R12 unmapped write ignored");
        rd(4, "R12 status after write");
        rd(3, "R12 ctrl after ro writes");
        rd(5, "R12 cdiv after ro writes");
        rd(7, "R12 unmapped read");

        // R2 held request: ack, gap, ack
        push(1'b1, status, 1'b0, "R2 held read 1");
        push(1'b1, status, 1'b0, "R2 held read 2");
        @(negedge clk);
        cyc = 1'b1; stb = 1'b1; we = 1'b0; adr = 5'h10;
        @(negedge clk);
        check("R2 first ack", {63'd0, ack}, 64'd1);
        @(negedge clk);
        check("R2 gap cycle", {63'd0, ack}, 64'd0);
        @(negedge clk);
        check("R2 second ack", {63'd0, ack}, 64'd1);
        cyc = 1'b0; stb = 1'b0;
        repeat (3) @(negedge clk);
        check("R2 queue drained", {32'd0, 32'(sb.size())}, 64'd0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule